// File: doc/BRIEF.md
# Immediate-Operand SIMD Lane ALU

This block is one execution slot of a vector unit. It takes a 32-bit instruction word and a 128-bit source vector and, in a single pass, applies one element-by-element operation between every lane of the source and a small constant held in the instruction. The lane width is chosen by a two-bit format field, so the same hardware serves sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes.

The operations are wrapping add and subtract, equality, signed and unsigned less-than and less-or-equal, and signed and unsigned maximum and minimum. Compares produce a lane mask: all ones if the condition holds, all zeros if it does not. A load-constant operation ignores the source and writes a sign-extended 10-bit constant into every lane. The result and the destination register index are registered, so they appear one clock after the instruction is presented. The register file, hazard logic and exceptions belong to the surrounding pipeline.

A two-state controller drives the output flag. In `ST_IDLE` no result is offered. A cycle with `in_valid` high and a recognised instruction moves it to `ST_EMIT` (transition *accept*), in which `out_valid` is high for that cycle. From either state, a cycle with no recognised instruction returns it to `ST_IDLE` (transition *drop*); back-to-back recognised instructions keep it in `ST_EMIT` (transition *repeat*). Reset forces `ST_IDLE`.

Top module: `simd_imm_alu`

## Requirements
- R1: During and directly after reset `out_valid` is 0 and `out_vec` and `out_dst` are 0.
- R2: An instruction is recognised when bits 31:26 equal 6'h1E and bits 5:0 equal 6'h06 (arithmetic group) or 6'h07 (compare group) with a defined selector in bits 25:23; one clock after a recognised instruction with `in_valid` high, `out_valid` is 1 and `out_dst` equals bits 10:6 of that instruction.
- R3: An unrecognised instruction with `in_valid` high gives `out_valid` 0 on the next clock and leaves `out_vec` and `out_dst` unchanged. Undefined selectors are 6 and 7 in the arithmetic group, and 1 and 7 in the compare group.
- R4: Bits 22:21 select the lane width: 0 gives 8-bit, 1 gives 16-bit, 2 gives 32-bit, 3 gives 64-bit lanes; lane k occupies bits k*W and up of both vectors.
- R5: Arithmetic selector 0 adds and selector 1 subtracts the zero-extended bits 20:16 to or from each lane, wrapping modulo 2^W.
- R6: Compare selector 0 writes all ones to a lane equal to the sign-extended bits 20:16 and all zeros otherwise.
- R7: Compare selector 2 (less-than) and 4 (less-or-equal) compare each lane as a signed W-bit value against the sign-extended bits 20:16, writing an all-ones or all-zeros mask.
- R8: Compare selector 3 (less-than) and 5 (less-or-equal) compare each lane as an unsigned W-bit value against the zero-extended bits 20:16, writing an all-ones or all-zeros mask.
- R9: Arithmetic selector 2 (maximum) and 4 (minimum) pick, per lane, the signed-larger or signed-smaller of the lane and the sign-extended bits 20:16, returning the chosen value unchanged.
- R10: Arithmetic selector 3 (maximum) and 5 (minimum) do the same as R9 with unsigned W-bit lanes and the zero-extended bits 20:16.
- R11: Compare selector 6 writes bits 20:11, taken as a signed 10-bit constant and sign-extended to W, into every lane; for 8-bit lanes the low 8 bits of the constant are written.
- R12: A cycle with `in_valid` low gives `out_valid` 0 on the next clock and leaves `out_vec` and `out_dst` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and source vector are valid this cycle |
| instr | input | 32 | Immediate-format vector instruction |
| src_vec | input | 128 | Source vector read from the register file |
| out_valid | output | 1 | Registered result is valid |
| out_dst | output | 5 | Destination register index of the registered result |
| out_vec | output | 128 | Registered result vector |

## Verification
The bench aims at lanes holding the most negative value, the most positive value, zero and all ones, paired with immediates 0x00, 0x0F, 0x10 and 0x1F, where signed and unsigned readings disagree; a design that extended the immediate the wrong way, or compared unsigned lanes at a wider width than the lane, would return the wrong mask or the wrong winner in exactly these lanes. Add and subtract near the lane limits catch carries leaking into the neighbouring lane. Load-constant is driven with constants whose bit 9 and bits 9:8 differ from bit 7, so a byte path that sign-extended from bit 9 or a wider path that failed to extend would show up. Undefined selectors, a wrong major field and idle cycles check that the flag drops and the previous result is held rather than overwritten.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

    localparam int VEC_W    = 128;
    localparam int IDX_W    = 5;
    localparam int IMM_W    = 5;
    localparam int CONST_W  = 10;
    localparam int N_FMT    = 4;

    localparam logic [5:0] MAJOR_VEC   = 6'h1E;
    localparam logic [5:0] MINOR_ARITH = 6'h06;
    localparam logic [5:0] MINOR_CMP   = 6'h07;

    typedef enum logic [1:0] {
        FMT_B = 2'd0,
        FMT_H = 2'd1,
        FMT_W = 2'd2,
        FMT_D = 2'd3
    } lane_fmt_e;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_EQ,
        OP_LT_S,
        OP_LT_U,
        OP_LE_S,
        OP_LE_U,
        OP_MAX_S,
        OP_MAX_U,
        OP_MIN_S,
        OP_MIN_U,
        OP_LDC,
        OP_NONE
    } lane_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } emit_state_e;

    function automatic logic is_mask_op(lane_op_e op);
        return (op == OP_EQ) || (op == OP_LT_S) || (op == OP_LT_U) ||
               (op == OP_LE_S) || (op == OP_LE_U);
    endfunction

    function automatic logic is_pick_op(lane_op_e op);
        return (op == OP_MAX_S) || (op == OP_MAX_U) ||
               (op == OP_MIN_S) || (op == OP_MIN_U);
    endfunction

endpackage

// File: rtl/simd_imm_decode.sv
module simd_imm_decode
    import simd_imm_pkg::*;
(
    input  logic [31:0]          instr,
    output lane_op_e             op,
    output lane_fmt_e            fmt,
    output logic                 legal,
    output logic [IMM_W-1:0]     imm5,
    output logic [CONST_W-1:0]   imm10,
    output logic [IDX_W-1:0]     dst_idx
);

    logic [5:0] major_f;
    logic [5:0] minor_f;
    logic [2:0] sel_f;

    assign major_f = instr[31:26];
    assign sel_f   = instr[25:23];
    assign fmt     = lane_fmt_e'(instr[22:21]);
    assign imm5    = instr[20:16];
    assign imm10   = instr[20:11];
    assign dst_idx = instr[10:6];
    assign minor_f = instr[5:0];

    always_comb begin
        op = OP_NONE;
        if (major_f == MAJOR_VEC) begin
            unique case (minor_f)
                MINOR_ARITH: begin
                    unique case (sel_f)
                        3'd0:    op = OP_ADD;
                        3'd1:    op = OP_SUB;
                        3'd2:    op = OP_MAX_S;
                        3'd3:    op = OP_MAX_U;
                        3'd4:    op = OP_MIN_S;
                        3'd5:    op = OP_MIN_U;
                        default: op = OP_NONE;
                    endcase
                end
                MINOR_CMP: begin
                    unique case (sel_f)
                        3'd0:    op = OP_EQ;
                        3'd2:    op = OP_LT_S;
                        3'd3:    op = OP_LT_U;
                        3'd4:    op = OP_LE_S;
                        3'd5:    op = OP_LE_U;
                        3'd6:    op = OP_LDC;
                        default: op = OP_NONE;
                    endcase
                end
                default: op = OP_NONE;
            endcase
        end
    end

    assign legal = (op != OP_NONE);

endmodule

// File: rtl/simd_imm_lane.sv
module simd_imm_lane
    import simd_imm_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_op_e           op,
    input  logic [W-1:0]       a,
    input  logic [IMM_W-1:0]   imm5,
    input  logic [W-1:0]       ldc_val,
    output logic [W-1:0]       res
);

    localparam int PAD = W - IMM_W;

    logic [W-1:0] imm_s;
    logic [W-1:0] imm_u;
    logic         eq_s;
    logic         lt_s;
    logic         lt_u;
    logic         gt_s;
    logic         gt_u;

    assign imm_s = {{PAD{imm5[IMM_W-1]}}, imm5};
    assign imm_u = {{PAD{1'b0}}, imm5};

    assign eq_s = (a == imm_s);
    assign lt_s = ($signed(a) < $signed(imm_s));
    assign gt_s = ($signed(a) > $signed(imm_s));
    assign lt_u = (a < imm_u);
    assign gt_u = (a > imm_u);

    always_comb begin
        unique case (op)
            OP_ADD:   res = a + imm_u;
            OP_SUB:   res = a - imm_u;
            OP_EQ:    res = {W{eq_s}};
            OP_LT_S:  res = {W{lt_s}};
            OP_LE_S:  res = {W{lt_s | eq_s}};
            OP_LT_U:  res = {W{lt_u}};
            OP_LE_U:  res = {W{lt_u | (a == imm_u)}};
            OP_MAX_S: res = gt_s ? a : imm_s;
            OP_MIN_S: res = lt_s ? a : imm_s;
            OP_MAX_U: res = gt_u ? a : imm_u;
            OP_MIN_U: res = lt_u ? a : imm_u;
            OP_LDC:   res = ldc_val;
            default:  res = '0;
        endcase
    end

    // R6 R7 R8: compare results are whole-lane masks
    always_comb begin
        if (is_mask_op(op)) begin
            a_r6_mask_shape: assert ((res == '0) || (res == '1));
        end
    end

    // R9 R10: max and min return one of their two inputs untouched
    always_comb begin
        if ((op == OP_MAX_S) || (op == OP_MIN_S)) begin
            a_r9_pick_signed: assert ((res == a) || (res == imm_s));
        end
        if ((op == OP_MAX_U) || (op == OP_MIN_U)) begin
            a_r10_pick_unsigned: assert ((res == a) || (res == imm_u));
        end
    end

endmodule

// File: rtl/simd_imm_ctrl.sv
module simd_imm_ctrl
    import simd_imm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic legal,
    output logic accept,
    output logic out_valid
);

    emit_state_e state_q;
    emit_state_e state_d;

    assign accept = in_valid && legal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = accept ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    // R12: idle input never produces a result next cycle
    a_r12_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/simd_imm_alu.sv
module simd_imm_alu
    import simd_imm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [VEC_W-1:0]    src_vec,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_dst,
    output logic [VEC_W-1:0]    out_vec
);

    lane_op_e               op;
    lane_fmt_e              fmt;
    logic                   legal;
    logic [IMM_W-1:0]       imm5;
    logic [CONST_W-1:0]     imm10;
    logic [IDX_W-1:0]       dst_idx;
    logic                   accept;
    logic [N_FMT-1:0][VEC_W-1:0] fmt_res;
    logic [VEC_W-1:0]       sel_res;

    simd_imm_decode u_dec (
        .instr   (instr),
        .op      (op),
        .fmt     (fmt),
        .legal   (legal),
        .imm5    (imm5),
        .imm10   (imm10),
        .dst_idx (dst_idx)
    );

    simd_imm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .legal     (legal),
        .accept    (accept),
        .out_valid (out_valid)
    );

    for (genvar gf = 0; gf < N_FMT; gf++) begin : g_fmt
        localparam int LW = 8 << gf;
        localparam int NL = VEC_W / LW;

        logic [LW-1:0] ldc_w;

        if (LW < CONST_W) begin : g_trunc
            assign ldc_w = imm10[LW-1:0];
        end else begin : g_ext
            assign ldc_w = {{(LW-CONST_W){imm10[CONST_W-1]}}, imm10};
        end

        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            simd_imm_lane #(.W(LW)) u_lane (
                .op      (op),
                .a       (src_vec[gl*LW +: LW]),
                .imm5    (imm5),
                .ldc_val (ldc_w),
                .res     (fmt_res[gf][gl*LW +: LW])
            );
        end
    end

    always_comb begin
        unique case (fmt)
            FMT_B:   sel_res = fmt_res[0];
            FMT_H:   sel_res = fmt_res[1];
            FMT_W:   sel_res = fmt_res[2];
            FMT_D:   sel_res = fmt_res[3];
            default: sel_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec <= '0;
            out_dst <= '0;
        end else if (accept) begin
            out_vec <= sel_res;
            out_dst <= dst_idx;
        end
    end

    // R2: a recognised instruction yields a result with its destination
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal) |=> (out_valid && (out_dst == $past(instr[10:6]))));

    // R3: an unrecognised instruction raises no result
    a_r3_bad_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> !out_valid);

    // R3 R12: without acceptance the previous result is held
    a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && legal) |=> ($stable(out_vec) && $stable(out_dst)));

endmodule

// File: tb/tb_simd_imm_alu.sv
module tb_simd_imm_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic         out_valid;
    logic [4:0]   out_dst;
    logic [127:0] out_vec;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic         exp_valid = 1'b0;
    logic [4:0]   exp_dst = '0;
    logic [127:0] exp_vec = '0;
    string        exp_tag = "R1";

    simd_imm_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .src_vec   (src_vec),
        .out_valid (out_valid),
        .out_dst   (out_dst),
        .out_vec   (out_vec)
    );

    always #2 clk = ~clk;

    function automatic longint sx(logic [63:0] v, int w);
        longint t;
        t = longint'(v << (64 - w));
        return t >>> (64 - w);
    endfunction

    // behavioural reference: R2..R11
    function automatic logic [127:0] model(input logic [31:0] ins, input logic [127:0] src,
                                           output bit ok, output string tag);
        int w, n, sel, grp;
        logic [63:0] m, u5, a, r, s10u;
        longint s5, sa;
        logic [127:0] acc;
        acc = '0;
        ok = 1'b0;
        tag = "R3";
        sel = int'(ins[25:23]);
        grp = (ins[5:0] == 6'h06) ? 1 : (ins[5:0] == 6'h07) ? 2 : 0;
        if (ins[31:26] != 6'h1E) grp = 0;
        if (grp == 1 && sel <= 5) ok = 1'b1;
        if (grp == 2 && sel != 1 && sel != 7) ok = 1'b1;
        if (!ok) return '0;
        w = 8 << ins[22:21];
        n = 128 / w;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        u5 = 64'(ins[20:16]);
        s5 = sx(u5, 5);
        s10u = 64'(sx(64'(ins[20:11]), 10));
        if (grp == 1) begin
            case (sel)
                0, 1: tag = "R5";
                2, 4: tag = "R9";
                default: tag = "R10";
            endcase
        end else begin
            case (sel)
                0: tag = "R6";
                2, 4: tag = "R7";
                3, 5: tag = "R8";
                default: tag = "R11";
            endcase
        end
        tag = {tag, "/R4"};
        for (int i = 0; i < n; i++) begin
            a = 64'(src >> (i * w)) & m;
            sa = sx(a, w);
            r = '0;
            if (grp == 1) begin
                case (sel)
                    0: r = a + u5;
                    1: r = a - u5;
                    2: r = (sa > s5) ? a : 64'(s5);
                    3: r = (a > u5) ? a : u5;
                    4: r = (sa < s5) ? a : 64'(s5);
                    default: r = (a < u5) ? a : u5;
                endcase
            end else begin
                case (sel)
                    0: r = (sa == s5) ? '1 : '0;
                    2: r = (sa < s5) ? '1 : '0;
                    3: r = (a < u5) ? '1 : '0;
                    4: r = (sa <= s5) ? '1 : '0;
                    5: r = (a <= u5) ? '1 : '0;
                    default: r = s10u;
                endcase
            end
            acc = acc | (128'(r & m) << (i * w));
        end
        return acc;
    endfunction

    always @(posedge clk) begin
        bit ok;
        string tg;
        logic [127:0] rv;
        cycles <= cycles + 1;
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_vec <= '0;
            exp_dst <= '0;
            exp_tag <= "R1";
        end else if (in_valid) begin
            rv = model(instr, src_vec, ok, tg);
            exp_tag <= tg;
            if (ok) begin
                exp_valid <= 1'b1;
                exp_vec <= rv;
                exp_dst <= instr[10:6];
            end else begin
                exp_valid <= 1'b0;
            end
        end else begin
            exp_valid <= 1'b0;
            exp_tag <= "R12";
        end
    end

    task automatic check_vec(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s vec actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, string what, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare every clock away from the active edge; the dst and vec checks cover R2 R3 R12
    always @(negedge clk) begin
        if (!done) begin
            check_bit(exp_tag, "valid", 6'(out_valid), 6'(exp_valid));
            check_bit(exp_tag, "dst", 6'(out_dst), 6'(exp_dst));
            check_vec(exp_tag, out_vec, exp_vec);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [127:0] fill(int df, logic [63:0] v);
        int w;
        logic [63:0] m;
        logic [127:0] acc;
        w = 8 << df;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        acc = '0;
        for (int i = 0; i < 128 / w; i++) acc = acc | (128'(v & m) << (i * w));
        return acc;
    endfunction

    function automatic logic [31:0] enc(logic [5:0] major, int sel, int df, logic [9:0] k,
                                        logic [4:0] wd, logic [5:0] minor);
        return {major, 3'(sel), 2'(df), k, wd, minor};
    endfunction

    task automatic send(logic [31:0] ins, logic [127:0] src);
        instr = ins;
        src_vec = src;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        instr = $urandom;
        src_vec = {$urandom, $urandom, $urandom, $urandom};
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [4:0]  imm_set [6];
        logic [9:0]  k10_set [6];
        logic [127:0] src;
        logic [9:0]  k;
        int nsend;
        nsend = 0;
        imm_set = '{5'h00, 5'h01, 5'h0F, 5'h10, 5'h1F, 5'h0A};
        k10_set = '{10'h000, 10'h3FF, 10'h1FF, 10'h200, 10'h0FF, 10'h17E};
        repeat (3) @(negedge clk);
        // R1 is checked by the comparator during and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        for (int df = 0; df < 4; df++) begin
            for (int g = 0; g < 2; g++) begin
                for (int sel = 0; sel < 8; sel++) begin
                    if (g == 0 && sel > 5) continue;
                    if (g == 1 && (sel == 1 || sel == 7)) continue;
                    for (int ii = 0; ii < 6; ii++) begin
                        for (int p = 0; p < 6; p++) begin
                            int w;
                            w = 8 << df;
                            case (p)
                                0: src = fill(df, 64'd1 << (w - 1));
                                1: src = fill(df, (w == 64) ? 64'h7FFF_FFFF_FFFF_FFFF
                                                             : ((64'd1 << (w - 1)) - 64'd1));
                                2: src = '1;
                                3: src = '0;
                                4: src = fill(df, 64'(imm_set[ii]));
                                default: src = {$urandom, $urandom, $urandom, $urandom};
                            endcase
                            if (g == 1 && sel == 6) k = k10_set[ii] ^ 10'(p);
                            else k = {imm_set[ii], 5'($urandom)};
                            send(enc(6'h1E, sel, df, k, 5'($urandom),
                                     (g == 0) ? 6'h06 : 6'h07), src);
                            nsend++;
                            if (nsend % 17 == 0) idle(2);
                        end
                    end
                end
            end
        end
        // R3: undefined selectors, wrong major, wrong minor
        for (int df = 0; df < 4; df++) begin
            send(enc(6'h1E, 0, df, 10'h155, 5'd9, 6'h06), {4{$urandom}});
            send(enc(6'h1E, 6, df, 10'h0AA, 5'd3, 6'h06), {4{$urandom}});
            send(enc(6'h1E, 7, df, 10'h0AA, 5'd4, 6'h06), {4{$urandom}});
            send(enc(6'h1E, 1, df, 10'h0AA, 5'd5, 6'h07), {4{$urandom}});
            send(enc(6'h1E, 7, df, 10'h0AA, 5'd6, 6'h07), {4{$urandom}});
            send(enc(6'h1F, 0, df, 10'h0AA, 5'd7, 6'h06), {4{$urandom}});
            send(enc(6'h1E, 0, df, 10'h0AA, 5'd8, 6'h05), {4{$urandom}});
            send(enc(6'h1E, 2, df, 10'h3E0, 5'd31, 6'h07), {4{$urandom}});
            // R12: garbage while idle must not disturb the held result
            idle(3);
        end
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule